// File: doc/BRIEF.md
# Packed SIMD Saturating Halving ALU

A purely combinational arithmetic unit for packed data in a 32-bit datapath. A 5-bit operation code picks how the two 32-bit operands are read: as two 16-bit halfword lanes, as four 8-bit byte lanes, or as one 32-bit word. The unit can do:

- unsigned halfword add and subtract, with or without clamping;
- halving add and subtract on bytes, halfwords and words, with or without round-half-up;
- byte absolute value with clamping;
- unsigned byte compares.

The unit has three kinds of output. The 32-bit result goes to the destination register. A one-cycle overflow pulse is ORed by the surrounding logic into a sticky status bit. A 4-bit condition value comes with a write strobe. The register file, decode and status storage all sit outside the block.

Top module: `packed_halving_alu`

## Requirements
- R1: Codes 0 (wrapping) and 1 (clamping) add each unsigned 16-bit lane. A lane sum above 0xFFFF sets the overflow pulse. Code 1 then forces that lane to 0xFFFF. Code 0 keeps the low 16 bits of the sum.
- R2: Codes 2 (wrapping) and 3 (clamping) subtract lane b from lane a on unsigned 16-bit lanes. A lane with a < b sets the overflow pulse. Code 3 then forces that lane to 0. Code 2 keeps the low 16 bits of the difference.
- R3: The overflow pulse is the OR over all lanes of their overflow events. It can be high only for codes 0 to 3 and 16.
- R4: Codes 4 to 7 act on unsigned byte lanes: 4 is add, 5 is add with rounding, 6 is subtract, 7 is subtract with rounding. Each lane forms x = a ± b at full precision, with negative differences in two's complement. The lane result is (x+1)>>1 with rounding, or x>>1 without, truncated to 8 bits.
- R5: Codes 8 to 11 act on signed 16-bit lanes, in the same order as R4. The shift is arithmetic and the result is truncated to 16 bits.
- R6: Codes 12 to 15 act on the whole word as a signed 32-bit value, in the same order as R4. The sum or difference is formed in 33 bits or more, so no overflow can occur.
- R7: Code 16 is byte absolute value. A byte of 0x80 becomes 0x7F and sets the overflow pulse. Other negative bytes are negated. Non-negative bytes pass through unchanged.
- R8: Codes 17 (equal), 18 (less than) and 19 (less or equal) compare unsigned byte lanes. The outcome for byte lane j (bits 8j+7..8j) goes to result bit j, and result bits 31..4 are zero. The condition output carries the same 4 bits, and the condition write strobe is high, so the whole field is overwritten.
- R9: The condition write strobe is low for every code other than 17 to 19.
- R10: Codes 20 to 31 give a zero result, no overflow pulse and no condition write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_o | output | 32 | Lane-packed result |
| ovf_set_o | output | 1 | Overflow set pulse, any lane |
| cond_o | output | 4 | Per-byte compare condition bits |
| cond_we_o | output | 1 | Condition field write strobe |

## Verification
Every operation code is swept over each pairing of the lane corner values 0x0000, 0x0001, 0x007F, 0x0080, 0x00FF, 0x7FFF, 0x8000 and 0xFFFF, placed in both halfwords with the operand order swapped.

- The halfword corners separate carry-out from no carry, and borrow from no borrow. They also expose the signed extremes where halving must shift arithmetically.
- The byte views of the same values (0x00, 0x7F, 0x80, 0xFF) hit the absolute-value clamp. They also give equal, less-than and greater-than byte pairs for the compares.
- Random operands then cover mixed-lane cases, so one lane's overflow or rounding carry is shown not to leak into its neighbour.

// File: rtl/packed_halving_alu.sv
module packed_halving_alu #(
  parameter int W = 32
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         ovf_set_o,
  output logic [3:0]   cond_o,
  output logic         cond_we_o
);
  localparam int HW = W / 2;
  localparam int BW = W / 4;

  logic is_ext, sub, mode;
  assign is_ext = op_i[4];
  assign sub    = op_i[1];
  assign mode   = op_i[0];

  logic [W-1:0] u_res, hh_res, bh_res, abs_res;
  logic [1:0]   u_ovf;
  logic [3:0]   abs_ovf, c_eq, c_lt;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] av, bv;
    logic [HW:0]   usum, udif;
    logic [HW+1:0] sx;
    logic          lane_ovf;
    assign av   = a_i[h*HW +: HW];
    assign bv   = b_i[h*HW +: HW];
    assign usum = {1'b0, av} + {1'b0, bv};
    assign udif = {1'b0, av} - {1'b0, bv};
    assign lane_ovf = sub ? udif[HW] : usum[HW];
    assign u_ovf[h] = lane_ovf;
    assign u_res[h*HW +: HW] = (mode && lane_ovf) ? (sub ? '0 : '1)
                                                   : (sub ? udif[HW-1:0] : usum[HW-1:0]);
    assign sx = (sub ? ({{2{av[HW-1]}}, av} - {{2{bv[HW-1]}}, bv})
                     : ({{2{av[HW-1]}}, av} + {{2{bv[HW-1]}}, bv}))
              + {{(HW+1){1'b0}}, mode};
    assign hh_res[h*HW +: HW] = sx[HW:1];
  end

  for (genvar k = 0; k < 4; k++) begin : g_byte
    logic [BW-1:0] av, bv;
    logic [BW+1:0] bx;
    assign av = a_i[k*BW +: BW];
    assign bv = b_i[k*BW +: BW];
    assign bx = (sub ? ({2'b00, av} - {2'b00, bv}) : ({2'b00, av} + {2'b00, bv}))
              + {{(BW+1){1'b0}}, mode};
    assign bh_res[k*BW +: BW] = bx[BW:1];
    assign abs_ovf[k] = (av == {1'b1, {(BW-1){1'b0}}});
    assign abs_res[k*BW +: BW] = abs_ovf[k] ? {1'b0, {(BW-1){1'b1}}}
                                 : (av[BW-1] ? (~av + 1'b1) : av);
    assign c_eq[k] = (av == bv);
    assign c_lt[k] = (av < bv);
  end

  logic [W+1:0] wx;
  assign wx = (sub ? ({{2{a_i[W-1]}}, a_i} - {{2{b_i[W-1]}}, b_i})
                   : ({{2{a_i[W-1]}}, a_i} + {{2{b_i[W-1]}}, b_i}))
            + {{(W+1){1'b0}}, mode};

  logic [3:0] cmp_bits;
  always_comb begin
    res_o     = '0;
    ovf_set_o = 1'b0;
    cmp_bits  = '0;
    cond_we_o = 1'b0;
    if (!is_ext) begin
      case (op_i[3:2])
        2'd0: begin res_o = u_res; ovf_set_o = |u_ovf; end
        2'd1: res_o = bh_res;
        2'd2: res_o = hh_res;
        default: res_o = wx[W:1];
      endcase
    end else if (op_i[3:2] == 2'd0) begin
      case (op_i[1:0])
        2'd0: begin res_o = abs_res; ovf_set_o = |abs_ovf; end
        2'd1: begin cmp_bits = c_eq;        cond_we_o = 1'b1; end
        2'd2: begin cmp_bits = c_lt;        cond_we_o = 1'b1; end
        default: begin cmp_bits = c_lt | c_eq; cond_we_o = 1'b1; end
      endcase
      if (op_i[1:0] != 2'd0) res_o = {{(W-4){1'b0}}, cmp_bits};
    end
  end
  assign cond_o = cmp_bits;

  always_comb begin
    if (cond_we_o) begin
      a_r8_cond_mirrors: assert (res_o[W-1:4] == '0 && res_o[3:0] == cond_o)
        else $error("compare result and condition disagree");
    end
    a_r9_we_only_cmp: assert (!cond_we_o || (op_i >= 5'd17 && op_i <= 5'd19))
      else $error("condition write on non-compare code");
    a_r3_flag_source: assert (!ovf_set_o || op_i <= 5'd3 || op_i == 5'd16)
      else $error("overflow pulse from non-overflowing code");
    if (op_i == 5'd16) begin
      for (int k = 0; k < 4; k++) begin
        a_r7_abs_nonneg: assert (res_o[k*BW+BW-1] == 1'b0)
          else $error("absolute value lane negative");
      end
    end
    if (op_i == 5'd1) begin
      for (int h = 0; h < 2; h++) begin
        a_r1_sat_ceiling: assert (res_o[h*HW +: HW] >= a_i[h*HW +: HW])
          else $error("clamped add lane below operand");
      end
    end
    if (op_i == 5'd3) begin
      for (int h = 0; h < 2; h++) begin
        a_r2_sat_floor: assert (res_o[h*HW +: HW] <= a_i[h*HW +: HW])
          else $error("clamped subtract lane above operand");
      end
    end
    if (op_i >= 5'd20) begin
      a_r10_unused_quiet: assert (res_o == '0 && !ovf_set_o && !cond_we_o)
        else $error("unused code produced output");
    end
  end
endmodule

// File: tb/test_packed_halving_alu.sv
module test_packed_halving_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  op;
  logic [31:0] a, b;
  logic [31:0] res;
  logic        ovf, we;
  logic [3:0]  cond;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  packed_halving_alu #(.W(32)) i_packed_halving_alu (
    .op_i(op), .a_i(a), .b_i(b), .res_o(res),
    .ovf_set_o(ovf), .cond_o(cond), .cond_we_o(we)
  );

  function automatic string tag(input int o);
    if (o <= 1) return "R1";
    if (o <= 3) return "R2";
    if (o <= 7) return "R4";
    if (o <= 11) return "R5";
    if (o <= 15) return "R6";
    if (o == 16) return "R7";
    if (o <= 19) return "R8";
    return "R10";
  endfunction

  function automatic void model(input int o, input logic [31:0] x, input logic [31:0] y,
                                output logic [31:0] r, output logic f,
                                output logic [3:0] c, output logic e);
    int s, p, q;
    longint w;
    r = 0; f = 0; c = 0; e = 0;
    if (o <= 3) begin
      for (int h = 0; h < 2; h++) begin
        p = int'(x[h*16 +: 16]); q = int'(y[h*16 +: 16]);
        if (o <= 1) begin
          s = p + q;
          if (s > 65535) begin f = 1; if (o == 1) s = 65535; end
        end else begin
          s = p - q;
          if (p < q) begin f = 1; if (o == 3) s = 0; end
        end
        r[h*16 +: 16] = s[15:0];
      end
    end else if (o <= 7) begin
      for (int k = 0; k < 4; k++) begin
        p = int'(x[k*8 +: 8]); q = int'(y[k*8 +: 8]);
        s = (o >= 6) ? p - q : p + q;
        s = s + (o % 2);
        s = s >>> 1;
        r[k*8 +: 8] = s[7:0];
      end
    end else if (o <= 11) begin
      for (int h = 0; h < 2; h++) begin
        p = int'($signed(x[h*16 +: 16])); q = int'($signed(y[h*16 +: 16]));
        s = (o >= 10) ? p - q : p + q;
        s = s + (o % 2);
        s = s >>> 1;
        r[h*16 +: 16] = s[15:0];
      end
    end else if (o <= 15) begin
      w = (o >= 14) ? longint'($signed(x)) - longint'($signed(y))
                    : longint'($signed(x)) + longint'($signed(y));
      w = w + (o % 2);
      w = w >>> 1;
      r = w[31:0];
    end else if (o == 16) begin
      for (int k = 0; k < 4; k++) begin
        p = int'($signed(x[k*8 +: 8]));
        if (p == -128) begin f = 1; p = 127; end
        else if (p < 0) p = -p;
        r[k*8 +: 8] = p[7:0];
      end
    end else if (o <= 19) begin
      e = 1;
      for (int k = 0; k < 4; k++) begin
        p = int'(x[k*8 +: 8]); q = int'(y[k*8 +: 8]);
        c[k] = (o == 17) ? (p == q) : (o == 18) ? (p < q) : (p <= q);
      end
      r = {28'd0, c};
    end
  endfunction

  task automatic check_one(input int o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er; logic ef, ee; logic [3:0] ec;
    @(negedge clk);
    op = o[4:0]; a = x; b = y;
    #1;
    model(o, x, y, er, ef, ec, ee);
    checks++;
    if (res !== er) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h res actual %h expected %h", tag(o), o, x, y, res, er);
    end else if (ovf !== ef) begin
      errors++;
      $display("FAIL R3 op=%0d a=%h b=%h ovf actual %b expected %b", o, x, y, ovf, ef);
    end else if (we !== ee || (ee && cond !== ec)) begin
      errors++;
      $display("FAIL %s op=%0d cond/we actual %h/%b expected %h/%b",
               (ee ? "R8" : "R9"), o, cond, we, ec, ee);
    end
  endtask

  logic [15:0] corner [8] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080,
                              16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    op = 0; a = 0; b = 0;
    repeat (3) @(posedge clk);
    check_one(0, 32'h0, 32'h0);
    check_one(1, 32'hFFFF_0001, 32'h0001_FFFF);
    check_one(3, 32'h0000_0005, 32'h0001_0003);
    check_one(16, 32'h8081_7F00, 32'h0);
    check_one(19, 32'h0102_FF80, 32'h0201_FF7F);
    for (int o = 0; o < 32; o++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          check_one(o, {corner[i], corner[j]}, {corner[j], corner[i]});
      for (int n = 0; n < 150; n++)
        check_one(o, $urandom, $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule